// File: doc/BRIEF.md
# Divide Unit Issue Controller

This block sits beside the decode stage of a pipeline and manages the occupancy of one or two long-latency, unpipelined divide units. Decode presents a divide request with a destination register tag and an operand. The controller places the request on a free unit, or refuses it when every unit is busy. A placed operation holds its unit for a fixed number of cycles. When it finishes, the controller returns the tag and the operand on a one-cycle completion strobe for writeback. The operand stands in for the quotient, because the arithmetic is outside this block.

For each unit, the controller drives a look-ahead flag that tells decode whether that unit can accept an operation on the next clock edge. Decode can therefore form its stall decision one cycle early. With two units, back-to-back divides go to alternate units and neither one stalls. With a single unit, a second divide waits in decode until the first has left the unit.

Top module: `divq_ctrl`

## Requirements
- R1: After reset, every bit of `unit_ready_next` is 1, `done_valid` is 0 and `issue_taken` is 0 while `issue_valid` is 0.
- R2: A request sampled when unit 0 is free is placed on unit 0. Its completion reports `done_unit` = 0.
- R3: With two units, a request sampled while unit 0 is busy and unit 1 is free is placed on unit 1, with `issue_taken` = 1. Two requests on consecutive edges are therefore both taken.
- R4: A request sampled while every unit is busy has `issue_taken` = 0. The request is dropped and produces no completion.
- R5: A unit that takes a request on edge t can take the next request no earlier than edge t + DIV_CYCLES, and it can take one on exactly that edge.
- R6: `unit_ready_next[i]` is 1 exactly when unit i will be able to take a request on the next edge. That holds when the unit is one cycle from finishing, or when it is idle and is not being loaded on the current edge.
- R7: A request taken on edge t produces `done_valid` = 1 for the single cycle that follows edge t + DIV_CYCLES. In that cycle, `done_tag`, `done_data` and `done_unit` carry the request's tag, its operand and the index of the unit that ran it.
- R8: With N_UNITS = 1, a second request made before the unit frees is refused, and the unit is reused as soon as its DIV_CYCLES have elapsed.
- R9: The number of completions equals the number of taken requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Decode has a divide to place this cycle |
| issue_tag | input | TAG_W | Destination register tag of the request |
| issue_data | input | DATA_W | Operand carried through to completion |
| issue_taken | output | 1 | The request is placed on a unit at this edge |
| unit_ready_next | output | N_UNITS | Per unit: able to take a request on the next edge |
| done_valid | output | 1 | One-cycle completion strobe |
| done_unit | output | IDX_W | Unit that produced the completion |
| done_tag | output | TAG_W | Destination tag of the completed operation |
| done_data | output | DATA_W | Result placeholder, which is the carried operand |

## Verification
A unit counter that is stuck or loaded wrongly shows up within one cycle as a disagreement between `unit_ready_next` and whether the following request is taken. It then shows up DIV_CYCLES cycles later as a completion that is early, late or missing. A tag or operand that is stored in the wrong slot surfaces only at completion, in `done_tag`, `done_data` or `done_unit`. A dispatch error surfaces immediately, as a wrong `issue_taken` for a request that meets all units busy, or that meets only unit 1 free. The bench sweeps request gaps from zero up past DIV_CYCLES on a two-unit and a one-unit configuration. It compares each cycle with a timeline kept as the edge number at which each unit frees.

// File: rtl/divq_pkg.sv
package divq_pkg;

  // A unit can take work next edge if it is one step from finishing,
  // or if it is idle and nothing is loading it now.
  function automatic logic look_ahead_free(input logic cnt_zero,
                                           input logic cnt_one,
                                           input logic loading);
    return cnt_one | (cnt_zero & ~loading);
  endfunction

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/divq_slot.sv
module divq_slot #(
  parameter int DIV_CYCLES = 25,
  parameter int TAG_W      = 5,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [TAG_W-1:0]  load_tag,
  input  logic [DATA_W-1:0] load_data,
  input  logic              drain,
  output logic              free_now,
  output logic              ready_next,
  output logic              pend,
  output logic [TAG_W-1:0]  pend_tag,
  output logic [DATA_W-1:0] pend_data
);
  localparam int CNT_W = (DIV_CYCLES > 2) ? $clog2(DIV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(DIV_CYCLES - 1);

  logic [CNT_W-1:0]  cnt;
  logic [TAG_W-1:0]  work_tag;
  logic [DATA_W-1:0] work_data;
  logic              cnt_zero;
  logic              cnt_one;

  assign cnt_zero   = (cnt == '0);
  assign cnt_one    = (cnt == CNT_W'(1));
  assign free_now   = cnt_zero;
  assign ready_next = divq_pkg::look_ahead_free(cnt_zero, cnt_one, load);

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= LOAD_VAL;
    else if (!cnt_zero) cnt <= cnt - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (load) begin
      work_tag  <= load_tag;
      work_data <= load_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          pend <= 1'b0;
    else if (cnt_one) pend <= 1'b1;
    else if (drain)   pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (cnt_one) begin
      pend_tag  <= work_tag;
      pend_data <= work_data;
    end
  end
endmodule

// File: rtl/divq_pick.sv
module divq_pick #(
  parameter int N_UNITS = 2
) (
  input  logic               req,
  input  logic [N_UNITS-1:0] free,
  output logic [N_UNITS-1:0] grant
);
  generate
    if (N_UNITS == 1) begin : g_single
      assign grant[0] = req & free[0];
    end else begin : g_dual
      assign grant[0] = req & free[0];
      assign grant[1] = req & ~free[0] & free[1];
    end
  endgenerate
endmodule

// File: rtl/divq_report.sv
module divq_report #(
  parameter int N_UNITS = 2,
  parameter int TAG_W   = 5,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [N_UNITS-1:0]             pend,
  input  logic [N_UNITS-1:0][TAG_W-1:0]  pend_tag,
  input  logic [N_UNITS-1:0][DATA_W-1:0] pend_data,
  output logic [N_UNITS-1:0]             drain,
  output logic                           done_valid,
  output logic [IDX_W-1:0]               done_unit,
  output logic [TAG_W-1:0]               done_tag,
  output logic [DATA_W-1:0]              done_data
);
  logic [TAG_W-1:0]  sel_tag;
  logic [DATA_W-1:0] sel_data;
  logic [IDX_W-1:0]  sel_idx;

  generate
    if (N_UNITS == 1) begin : g_single
      assign drain    = pend;
      assign sel_tag  = pend_tag[0];
      assign sel_data = pend_data[0];
      assign sel_idx  = '0;
    end else begin : g_dual
      // unit 0 reports first; unit 1 keeps its result one more cycle
      assign drain[0] = pend[0];
      assign drain[1] = pend[1] & ~pend[0];
      assign sel_tag  = pend[0] ? pend_tag[0]  : pend_tag[1];
      assign sel_data = pend[0] ? pend_data[0] : pend_data[1];
      assign sel_idx  = pend[0] ? IDX_W'(0)    : IDX_W'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) done_valid <= 1'b0;
    else     done_valid <= |pend;
  end

  always_ff @(posedge clk) begin
    if (|pend) begin
      done_tag  <= sel_tag;
      done_data <= sel_data;
      done_unit <= sel_idx;
    end
  end
endmodule

// File: rtl/divq_ctrl.sv
module divq_ctrl #(
  parameter int N_UNITS    = 2,
  parameter int DIV_CYCLES = 25,
  parameter int TAG_W      = 5,
  parameter int DATA_W     = 32,
  localparam int IDX_W     = divq_pkg::idx_width(N_UNITS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               issue_valid,
  input  logic [TAG_W-1:0]   issue_tag,
  input  logic [DATA_W-1:0]  issue_data,
  output logic               issue_taken,
  output logic [N_UNITS-1:0] unit_ready_next,
  output logic               done_valid,
  output logic [IDX_W-1:0]   done_unit,
  output logic [TAG_W-1:0]   done_tag,
  output logic [DATA_W-1:0]  done_data
);
  logic [N_UNITS-1:0]             slot_free;
  logic [N_UNITS-1:0]             slot_ready;
  logic [N_UNITS-1:0]             slot_grant;
  logic [N_UNITS-1:0]             slot_pend;
  logic [N_UNITS-1:0]             slot_drain;
  logic [N_UNITS-1:0][TAG_W-1:0]  slot_tag;
  logic [N_UNITS-1:0][DATA_W-1:0] slot_data;

  divq_pick #(.N_UNITS(N_UNITS)) u_pick (
    .req   (issue_valid),
    .free  (slot_free),
    .grant (slot_grant)
  );

  generate
    for (genvar i = 0; i < N_UNITS; i++) begin : g_slot
      divq_slot #(
        .DIV_CYCLES (DIV_CYCLES),
        .TAG_W      (TAG_W),
        .DATA_W     (DATA_W)
      ) u_slot (
        .clk        (clk),
        .rst        (rst),
        .load       (slot_grant[i]),
        .load_tag   (issue_tag),
        .load_data  (issue_data),
        .drain      (slot_drain[i]),
        .free_now   (slot_free[i]),
        .ready_next (slot_ready[i]),
        .pend       (slot_pend[i]),
        .pend_tag   (slot_tag[i]),
        .pend_data  (slot_data[i])
      );
    end
  endgenerate

  divq_report #(
    .N_UNITS (N_UNITS),
    .TAG_W   (TAG_W),
    .DATA_W  (DATA_W),
    .IDX_W   (IDX_W)
  ) u_report (
    .clk        (clk),
    .rst        (rst),
    .pend       (slot_pend),
    .pend_tag   (slot_tag),
    .pend_data  (slot_data),
    .drain      (slot_drain),
    .done_valid (done_valid),
    .done_unit  (done_unit),
    .done_tag   (done_tag),
    .done_data  (done_data)
  );

  assign issue_taken     = |slot_grant;
  assign unit_ready_next = slot_ready;
endmodule

// File: rtl/divq_ctrl_chk.sv
module divq_ctrl_chk #(
  parameter int N_UNITS = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               issue_valid,
  input logic               issue_taken,
  input logic [N_UNITS-1:0] ready_next,
  input logic [N_UNITS-1:0] free_now,
  input logic [N_UNITS-1:0] grant
);
  assert_taken_needs_room_R4: assert property (@(posedge clk) disable iff (rst)
    issue_taken |-> (issue_valid && (|free_now)))
    else $error("taken without request or free unit");

  assert_one_unit_per_issue_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant))
    else $error("request granted to more than one unit");

  generate
    for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
      assert_ready_honoured_R6: assert property (@(posedge clk) disable iff (rst)
        ready_next[i] |=> free_now[i])
        else $error("unit %0d flagged ready but not free", i);

      assert_busy_honoured_R6: assert property (@(posedge clk) disable iff (rst)
        !ready_next[i] |=> !free_now[i])
        else $error("unit %0d flagged busy but free", i);

      assert_load_occupies_R5: assert property (@(posedge clk) disable iff (rst)
        grant[i] |=> !free_now[i])
        else $error("unit %0d free right after load", i);
    end
  endgenerate
endmodule

bind divq_ctrl divq_ctrl_chk #(.N_UNITS(N_UNITS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .issue_valid (issue_valid),
  .issue_taken (issue_taken),
  .ready_next  (unit_ready_next),
  .free_now    (slot_free),
  .grant       (slot_grant)
);

// File: tb/test_divq_ctrl.sv
module test_divq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 5;
  localparam int DW = 16;
  localparam int CYC0 = 5;
  localparam int CYC1 = 4;
  localparam int NU0 = 2;
  localparam int NU1 = 1;
  localparam int DEPTH = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iv = 1'b0;
  logic [TW-1:0] itag = '0;
  logic [DW-1:0] idata = '0;

  logic tk0, tk1, dv0, dv1;
  logic [1:0] rn0;
  logic [0:0] rn1, du0, du1;
  logic [TW-1:0] dt0, dt1;
  logic [DW-1:0] dd0, dd1;

  divq_ctrl #(.N_UNITS(NU0), .DIV_CYCLES(CYC0), .TAG_W(TW), .DATA_W(DW)) i_divq_ctrl (
    .clk(clk), .rst(rst), .issue_valid(iv), .issue_tag(itag), .issue_data(idata),
    .issue_taken(tk0), .unit_ready_next(rn0), .done_valid(dv0), .done_unit(du0),
    .done_tag(dt0), .done_data(dd0));

  divq_ctrl #(.N_UNITS(NU1), .DIV_CYCLES(CYC1), .TAG_W(TW), .DATA_W(DW)) i_divq_ctrl_one (
    .clk(clk), .rst(rst), .issue_valid(iv), .issue_tag(itag), .issue_data(idata),
    .issue_taken(tk1), .unit_ready_next(rn1), .done_valid(dv1), .done_unit(du1),
    .done_tag(dt1), .done_data(dd1));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  int nx = 0;
  int tg = 0;
  int fe[2][2];
  bit ev[2][DEPTH];
  int etg[2][DEPTH];
  int edt[2][DEPTH];
  int eun[2][DEPTH];
  int issued[2];
  int seen[2];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at edge %0d actual=%0d expected=%0d", req, nx, act, exp);
    end
  endtask

  task automatic model_cycle(input int c, input bit taken, input int rn, input bit dv,
                             input int du, input int dt, input int dd);
    int cyc = (c == 0) ? CYC0 : CYC1;
    int nu  = (c == 0) ? NU0 : NU1;
    int g = -1;
    string lbl;
    if (iv) begin
      for (int u = 0; u < nu; u++) if (g < 0 && nx >= fe[c][u]) g = u;
    end
    if (c == 1)               lbl = "R8";
    else if (iv && g < 0)     lbl = "R4";
    else if (g == 1)          lbl = "R3";
    else                      lbl = "R2";
    for (int u = 0; u < nu; u++) if (iv && fe[c][u] != 0 && nx == fe[c][u]) lbl = "R5";
    chk(taken == (g >= 0), lbl, int'(taken), int'(g >= 0));
    if (g >= 0) begin
      fe[c][g] = nx + cyc;
      ev[c][nx + cyc + 1] = 1'b1;
      etg[c][nx + cyc + 1] = int'(itag);
      edt[c][nx + cyc + 1] = int'(idata);
      eun[c][nx + cyc + 1] = g;
      issued[c]++;
    end
    for (int u = 0; u < nu; u++) begin
      int er = (fe[c][u] <= nx + 1) ? 1 : 0;
      chk(((rn >> u) & 1) == er, "R6", (rn >> u) & 1, er);
    end
    chk(dv == ev[c][nx], "R7", int'(dv), int'(ev[c][nx]));
    if (dv) seen[c]++;
    if (dv && ev[c][nx]) begin
      chk(dt == etg[c][nx], "R7", dt, etg[c][nx]);
      chk(dd == edt[c][nx], "R7", dd, edt[c][nx]);
      chk(du == eun[c][nx], (eun[c][nx] == 0) ? "R2" : "R3", du, eun[c][nx]);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input bit v);
    iv = v;
    itag = TW'(tg);
    idata = DW'(tg * 37 + 5);
    tg++;
    #1;
    model_cycle(0, tk0, int'(rn0), dv0, int'(du0), int'(dt0), int'(dd0));
    model_cycle(1, tk1, int'(rn1), dv1, int'(du1), int'(dt1), int'(dd1));
    nx++;
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] lfsr;
    for (int c = 0; c < 2; c++) begin
      issued[c] = 0;
      seen[c] = 0;
      for (int u = 0; u < 2; u++) fe[c][u] = 0;
      for (int k = 0; k < DEPTH; k++) ev[c][k] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(dv0 == 1'b0 && dv1 == 1'b0, "R1", int'(dv0) + int'(dv1), 0);
    chk(rn0 == 2'b11, "R1", int'(rn0), 3);
    chk(rn1 == 1'b1, "R1", int'(rn1), 1);
    chk(tk0 == 1'b0 && tk1 == 1'b0, "R1", int'(tk0) + int'(tk1), 0);
    for (int g = 0; g < CYC0 + 3; g++) begin
      for (int k = 0; k < 20; k++) step((k % (g + 1)) == 0);
      repeat (8) step(1'b0);
    end
    lfsr = 16'hACE1;
    for (int k = 0; k < 200; k++) begin
      step(lfsr[0] | lfsr[5]);
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end
    repeat (10) step(1'b0);
    chk(issued[0] == seen[0], "R9", seen[0], issued[0]);
    chk(issued[1] == seen[1], "R9", seen[1], issued[1]);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL R9 watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule